// File: doc/BRIEF.md
# Repeating Loopback Deactivate Code Detector

This block monitors the received serial bit stream of a T1 line for an inband code that repeats. The code is typically the three-bit loopback deactivate sequence 001. Software supplies the code as a pattern register together with its length. The detector counts milliseconds in fixed 48 ms windows. At the end of each window it raises a sticky detect flag if the code was present throughout the window with no more than 15 bit mismatches.

The code may arrive framed or unframed. In framed mode, bit positions that the framer marks as framing bits are left out of the comparison. In unframed mode, every valid bit is compared. Each window begins by hunting for the code: the detector shifts in received bits until the most recent `codeLen` bits equal the pattern. From that point it locks its phase and compares every later bit against the expected pattern bit. The detect flag stays set until a clear pulse removes it.

Top module: `loop_deact_det`

## Requirements
- R1: A synchronous active-high reset clears the detect flag, the hunt and lock state and the error count, and it restarts the 48-tick window. This holds even when reset arrives in the middle of a window.
- R2: When the stream is the pattern repeated cleanly, starting at any phase, `detect` is 1 in the cycle after the 48th `msTick` of the window. The pattern is sent with `codePattern[codeLen-1]` first and bit 0 last, so 001 is coded as `codePattern`=3'b001 with `codeLen`=3.
- R3: `detect` can only rise in the cycle after the `msTick` that closes a window. That is the 48th tick since reset or since the previous window end. It never rises earlier.
- R4: Once the phase is locked, each accepted bit that differs from the expected pattern bit counts as one error. A window that ends with 15 errors or fewer sets `detect`. A window with 16 or more errors does not set it.
- R5: With `framedMode`=1, valid bits that have `framingBit`=1 are skipped entirely. With `framedMode`=0, `framingBit` is ignored and those bits are compared like any other bit.
- R6: The code is taken from `codePattern` and `codeLen`. A stream in which the programmed pattern never appears produces no detection.
- R7: Bits received before the phase locks are not counted as errors. A window in which the phase never locks, for example an all-zero stream while looking for 001, does not set `detect`.
- R8: `detect` is sticky: it stays set through later windows that fail. `clearDet` clears it in the next cycle and wins over a detection in the same cycle.
- R9: Cycles with `bitValid`=0 have no effect on the comparison. A bit presented in the same cycle as the window-closing tick is discarded.
- R10: `codeLen` may take any value from 1 to MAX_LEN (8), and both ends of that range detect correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bitValid | input | 1 | Strobe that marks a valid received bit |
| bitData | input | 1 | Received data bit |
| framingBit | input | 1 | Current bit is in a framing-bit position |
| framedMode | input | 1 | 1 = framed code (skip framing bits), 0 = unframed |
| msTick | input | 1 | One-cycle pulse each millisecond |
| codePattern | input | MAX_LEN | Code pattern; bit codeLen-1 is sent first |
| codeLen | input | $clog2(MAX_LEN+1) | Pattern length, 1 to MAX_LEN |
| clearDet | input | 1 | Clears the sticky detect flag |
| detect | output | 1 | Sticky deactivate-code detect flag |

## Verification
The assertions assume three things about the inputs. `codeLen` stays in the range 1 to MAX_LEN. `codePattern` and `codeLen` change only between windows. `msTick` is a single-cycle pulse. The bench holds the code registers for the whole of each window and changes them only in cycles that accept no bit. It spaces ticks a fixed number of cycles apart and draws every length from the legal range. Random data appears only on cycles that are invalid, on framing-bit positions, or as deliberate flips counted against the error budget.

// File: rtl/loop_deact_pkg.sv
package loop_deact_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic restart;  // window closes: wipe hunt/lock/error state
    logic accept;   // a bit enters the comparison this cycle
    logic lockNow;  // hunt succeeds on this bit
    logic locked;   // phase already locked
  } ctlStrobe_t;
endpackage

// File: rtl/loop_deact_dp.sv
module loop_deact_dp
  import loop_deact_pkg::*;
#(
  parameter int MAX_LEN   = 8,
  parameter int ERR_LIMIT = 15,
  localparam int LEN_W    = $clog2(MAX_LEN + 1),
  localparam int ERR_W    = $clog2(ERR_LIMIT + 2)
) (
  input  logic               clk,
  input  logic               rst,
  input  ctlStrobe_t         strobe,
  input  logic               bitData,
  input  logic [MAX_LEN-1:0] codePattern,
  input  logic [LEN_W-1:0]   codeLen,
  output logic               patMatch,
  output logic               errOk,
  output logic [ERR_W-1:0]   errCnt
);
  localparam logic [ERR_W-1:0] ERR_SAT  = ERR_W'(ERR_LIMIT + 1);
  localparam logic [ERR_W-1:0] ERR_MAX  = ERR_W'(ERR_LIMIT);
  localparam logic [LEN_W-1:0] FILL_MAX = LEN_W'(MAX_LEN);

  logic [MAX_LEN-1:0] shiftReg, nextShift, lenMask;
  logic [LEN_W-1:0]   fillCnt, phase, expIdx;
  logic               expBit, mismatch;

  always_comb begin
    nextShift = {shiftReg[MAX_LEN-2:0], bitData};
    lenMask   = {MAX_LEN{1'b1}} >> (MAX_LEN - int'(codeLen));
    patMatch  = (int'(fillCnt) + 1 >= int'(codeLen)) &&
                ((nextShift & lenMask) == (codePattern & lenMask));
    expIdx    = codeLen - 1'b1 - phase;
    expBit    = 1'b0;
    for (int i = 0; i < MAX_LEN; i++)
      if (i == int'(expIdx)) expBit = codePattern[i];
    mismatch  = bitData != expBit;
    errOk     = errCnt <= ERR_MAX;
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.restart) begin
      shiftReg <= '0;
      fillCnt  <= '0;
      phase    <= '0;
      errCnt   <= '0;
    end else if (strobe.accept) begin
      shiftReg <= nextShift;
      if (fillCnt != FILL_MAX) fillCnt <= fillCnt + 1'b1;
      if (strobe.lockNow) begin
        phase <= '0;
      end else if (strobe.locked) begin
        phase <= (phase == codeLen - 1'b1) ? '0 : phase + 1'b1;
        if (mismatch && errCnt != ERR_SAT) errCnt <= errCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/loop_deact_ctrl.sv
module loop_deact_ctrl
  import loop_deact_pkg::*;
#(
  parameter int WINDOW_MS = 48,
  localparam int WIN_W    = $clog2(WINDOW_MS)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bitValid,
  input  logic       framingBit,
  input  logic       framedMode,
  input  logic       msTick,
  input  logic       clearDet,
  input  logic       patMatch,
  input  logic       errOk,
  output ctlStrobe_t strobe,
  output logic       detect
);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW_MS - 1);

  logic [WIN_W-1:0] winCnt;
  logic             lockedQ, winEnd, accept, lockNow;

  always_comb begin
    winEnd  = msTick && (winCnt == WIN_LAST);
    accept  = bitValid && !(framedMode && framingBit) && !winEnd;
    lockNow = accept && !lockedQ && patMatch;
    strobe  = '{restart: winEnd, accept: accept, lockNow: lockNow, locked: lockedQ};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      winCnt  <= '0;
      lockedQ <= 1'b0;
      detect  <= 1'b0;
    end else begin
      if (msTick) winCnt <= winEnd ? '0 : winCnt + 1'b1;
      if (winEnd)       lockedQ <= 1'b0;
      else if (lockNow) lockedQ <= 1'b1;
      if (clearDet)                          detect <= 1'b0;
      else if (winEnd && lockedQ && errOk)   detect <= 1'b1;
    end
  end
endmodule

// File: rtl/loop_deact_det.sv
module loop_deact_det
  import loop_deact_pkg::*;
#(
  parameter int MAX_LEN   = 8,
  parameter int ERR_LIMIT = 15,
  parameter int WINDOW_MS = 48,
  localparam int LEN_W    = $clog2(MAX_LEN + 1),
  localparam int ERR_W    = $clog2(ERR_LIMIT + 2)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bitValid,
  input  logic               bitData,
  input  logic               framingBit,
  input  logic               framedMode,
  input  logic               msTick,
  input  logic [MAX_LEN-1:0] codePattern,
  input  logic [LEN_W-1:0]   codeLen,
  input  logic               clearDet,
  output logic               detect
);
  ctlStrobe_t       strobe;
  logic             patMatch, errOk, locked;
  logic [ERR_W-1:0] errCnt;

  assign locked = strobe.locked;

  loop_deact_ctrl #(.WINDOW_MS(WINDOW_MS)) u_ctrl (
    .clk(clk), .rst(rst), .bitValid(bitValid), .framingBit(framingBit),
    .framedMode(framedMode), .msTick(msTick), .clearDet(clearDet),
    .patMatch(patMatch), .errOk(errOk), .strobe(strobe), .detect(detect)
  );

  loop_deact_dp #(.MAX_LEN(MAX_LEN), .ERR_LIMIT(ERR_LIMIT)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .bitData(bitData),
    .codePattern(codePattern), .codeLen(codeLen),
    .patMatch(patMatch), .errOk(errOk), .errCnt(errCnt)
  );
endmodule

// File: rtl/loop_deact_chk.sv
module loop_deact_chk #(
  parameter int MAX_LEN   = 8,
  parameter int ERR_LIMIT = 15,
  parameter int LEN_W     = 4,
  parameter int ERR_W     = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             bitValid,
  input logic             msTick,
  input logic             clearDet,
  input logic [LEN_W-1:0] codeLen,
  input logic             detect,
  input logic             locked,
  input logic [ERR_W-1:0] errCnt
);
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clearDet |=> !detect); // R8
  AST_DETECT_STICKY: assert property (@(posedge clk) disable iff (rst)
    detect && !clearDet |=> detect); // R8
  AST_RISE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !detect && !msTick |=> !detect); // R3
  AST_RISE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    !detect && !locked |=> !detect); // R7
  AST_NO_ERR_BEFORE_LOCK: assert property (@(posedge clk) disable iff (rst)
    !locked |-> errCnt == '0); // R7
  AST_BUDGET_EXCEEDED: assert property (@(posedge clk) disable iff (rst)
    (int'(errCnt) > ERR_LIMIT) && !detect |=> !detect); // R4
  AST_INVALID_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    !bitValid && !msTick |=> $stable(errCnt)); // R9
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(codeLen) >= 1 && int'(codeLen) <= MAX_LEN); // R10
endmodule

bind loop_deact_det loop_deact_chk #(
  .MAX_LEN(MAX_LEN), .ERR_LIMIT(ERR_LIMIT), .LEN_W(LEN_W), .ERR_W(ERR_W)
) u_chk (
  .clk(clk), .rst(rst), .bitValid(bitValid), .msTick(msTick),
  .clearDet(clearDet), .codeLen(codeLen), .detect(detect),
  .locked(locked), .errCnt(errCnt)
);

// File: tb/loop_deact_det_bench.sv
module loop_deact_det_bench;
  localparam int TICK_GAP = 12;
  localparam int WIN      = 48;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bitValid = 0, bitData = 0, framingBit = 0, framedMode = 0;
  logic       msTick = 0, clearDet = 0;
  logic [7:0] codePattern = 8'b001;
  logic [3:0] codeLen = 4'd3;
  logic       detect;

  int nChk = 0, nFail = 0;
  // reference model state
  logic [7:0] mSr;
  int  mFill, mPhase, mErr, mWin;
  bit  mLocked, expDet;

  always #10 clk = ~clk;

  loop_deact_det u_loop_deact_det (
    .clk(clk), .rst(rst), .bitValid(bitValid), .bitData(bitData),
    .framingBit(framingBit), .framedMode(framedMode), .msTick(msTick),
    .codePattern(codePattern), .codeLen(codeLen), .clearDet(clearDet),
    .detect(detect)
  );

  task automatic modelClearState();
    mSr = '0; mFill = 0; mPhase = 0; mErr = 0; mLocked = 0;
  endtask

  function automatic bit patBit(int idx);
    return codePattern[int'(codeLen) - 1 - idx];
  endfunction

  task automatic modelCycle(bit v, bit d, bit f, bit t, bit c);
    bit winEnd, acc, newDet;
    logic [7:0] mask;
    winEnd = t && (mWin == WIN - 1);
    acc    = v && !(framedMode && f) && !winEnd;
    newDet = c ? 1'b0 : ((winEnd && mLocked && mErr <= 15) ? 1'b1 : expDet);
    if (acc) begin
      mSr = {mSr[6:0], d};
      if (mFill < 8) mFill++;
      if (!mLocked) begin
        mask = 8'hFF >> (8 - int'(codeLen));
        if (mFill >= int'(codeLen) && (mSr & mask) == (codePattern & mask)) begin
          mLocked = 1; mPhase = 0;
        end
      end else begin
        if (d != patBit(mPhase)) mErr++;
        mPhase = (mPhase + 1) % int'(codeLen);
      end
    end
    if (winEnd) modelClearState();
    if (t) mWin = winEnd ? 0 : mWin + 1;
    expDet = newDet;
  endtask

  task automatic step(bit v, bit d, bit f, bit t, bit c);
    @(negedge clk);
    bitValid = v; bitData = d; framingBit = f; msTick = t; clearDet = c;
    modelCycle(v, d, f, t, c);
    @(posedge clk);
    #1;
  endtask

  task automatic checkDet(string tag, int expv);
    bit e;
    e = (expv < 0) ? expDet : expv[0];
    nChk++;
    if (detect !== e) begin
      nFail++;
      $display("FAIL %s detect=%0b expected=%0b", tag, detect, e);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1; bitValid = 0; msTick = 0; clearDet = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 0;
    modelClearState(); mWin = 0; expDet = 0;
  endtask

  // one full window; expEnd < 0 means compare with the model
  task automatic runWindow(string tag, int nErr, bit frmJunk, bit zeros,
                           int rate, bit clrEnd, int expEnd);
    int gPh, errLeft, lockedCnt;
    bit startDet, v, d, f, t;
    gPh = $urandom % int'(codeLen);
    errLeft = nErr; lockedCnt = 0;
    startDet = detect;
    for (int k = 0; k < WIN; k++) begin
      for (int g = 0; g < TICK_GAP; g++) begin
        t = (g == TICK_GAP - 1);
        v = ($urandom % 100) < rate;
        f = frmJunk && v && ($urandom % 8 == 0);
        if (!v || f) d = $urandom;
        else if (zeros) d = 0;
        else begin
          d = patBit(gPh);
          gPh = (gPh + 1) % int'(codeLen);
          if (mLocked && !t && !(framedMode == 0 && f)) begin
            lockedCnt++;
            if (errLeft > 0 && lockedCnt % 5 == 0) begin
              d = ~d; errLeft--;
            end
          end
        end
        step(v, d, f, t, clrEnd && t && k == WIN - 1);
      end
      if (k == WIN - 2) checkDet({tag, " R3 no early rise"}, startDet);
    end
    checkDet(tag, expEnd);
  endtask

  task automatic clearFlag();
    step(0, 0, 0, 0, 1);
    checkDet("R8 clear", 0);
  endtask

  initial begin
    process::self().srandom(32'h5eed_0721);
    modelClearState(); mWin = 0; expDet = 0;
    doReset();
    #1 checkDet("R1 reset", 0);

    codePattern = 8'b001; codeLen = 3; framedMode = 0;
    runWindow("R2 clean 001", 0, 0, 0, 80, 0, 1);
    runWindow("R8 sticky over failing window", 0, 0, 1, 80, 0, 1);
    clearFlag();
    runWindow("R7 zeros never lock", 0, 0, 1, 80, 0, 0);
    runWindow("R4 15 errors", 15, 0, 0, 80, 0, 1);
    clearFlag();
    runWindow("R4 16 errors", 16, 0, 0, 80, 0, 0);

    framedMode = 1;
    runWindow("R5 framed skips framing bits", 0, 1, 0, 80, 0, 1);
    clearFlag();
    framedMode = 0;
    runWindow("R5 unframed compares framing bits", 0, 1, 0, 80, 0, 0);

    codePattern = 8'b10110; codeLen = 5;
    runWindow("R6 five-bit code", 0, 0, 0, 80, 0, 1);
    clearFlag();
    codePattern = 8'b011; codeLen = 3;
    // stream still 001 content: drive it under the 011 register
    begin
      int ph;
      ph = 0;
      for (int k = 0; k < WIN; k++)
        for (int g = 0; g < TICK_GAP; g++) begin
          step(1, (ph % 3) == 2, 0, g == TICK_GAP - 1, 0);
          ph++;
        end
      checkDet("R6 absent code", 0);
    end

    codePattern = 8'b11100100; codeLen = 8;
    runWindow("R10 eight-bit code", 0, 0, 0, 80, 0, 1);
    clearFlag();
    codePattern = 8'b1; codeLen = 1;
    runWindow("R10 one-bit code", 3, 0, 0, 80, 0, 1);
    codePattern = 8'b001; codeLen = 3;
    runWindow("R8 clear beats detection", 0, 0, 0, 80, 1, 0);
    runWindow("R9 sparse valid bits", 0, 0, 0, 35, 0, 1);
    clearFlag();

    // reset mid-window restarts the window count
    for (int i = 0; i < 20 * TICK_GAP; i++)
      step(1, 0, 0, (i % TICK_GAP) == TICK_GAP - 1, 0);
    doReset();
    #1 checkDet("R1 mid-window reset", 0);
    runWindow("R1 window restarts after reset", 0, 0, 0, 80, 0, 1);

    for (int w = 0; w < 18; w++) begin
      codeLen = 4'(1 + $urandom % 8);
      codePattern = 8'($urandom);
      framedMode = $urandom % 2;
      if ($urandom % 2 == 1) clearFlag();
      runWindow("R4 random window", $urandom % 26, framedMode, 0,
                40 + $urandom % 60, 0, -1);
    end

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule